// File: doc/BRIEF.md
# Interlaced Field Read Address Sequencer

This block generates the system-memory read addresses a bus master needs to fetch one field of a stored interlaced frame during playback. Software programs one base address for odd fields and another for even fields, a line pitch, a line count and a per-line byte count. A start pulse captures all of them, and the block then issues one Dword read request at a time over a valid/ready handshake.

Within a line the address climbs by 4 per Dword. At the end of each line the next line begins one pitch above the previous line's start. The pitch is independent of the active byte count, so a window can be cut out of a wider stored frame. When the last Dword of the last line has been accepted, the block pulses a done flag and switches to the other field's base for the next start. A pitch that is not Dword aligned, or an empty field, is refused with an error flag.

Top module: `field_addr_gen`

## Requirements
- R1: After reset, req_valid_o, busy_o, field_done_o and cfg_err_o are 0, and field_odd_o is 1, meaning the odd base is selected.
- R2: The first request after an accepted start carries the base of the selected field: base_odd_i when field_odd_o is 1, base_even_i when it is 0.
- R3: Inside a line each accepted request is followed by one 4 higher. A line holds ceil(num_bytes_i/4) requests.
- R4: The first request of every line after the first is the previous line's start address plus pitch_i.
- R5: A field holds num_lines_i lines. In the cycle after its last request is accepted, req_valid_o and busy_o are 0, field_done_o is 1 for exactly one cycle, and field_odd_o has inverted.
- R6: While req_valid_o is 1 and req_ready_i is 0, req_valid_o stays 1 and req_addr_o is unchanged on the next cycle. The address advances only on a handshake.
- R7: A start while idle is refused if pitch_i[1:0] is nonzero, num_lines_i is 0 or num_bytes_i is 0. The refusal sets cfg_err_o, and no request follows. A later accepted start clears cfg_err_o.
- R8: All parameters are captured at an accepted start. Parameter changes and start pulses while busy_o is 1 have no effect on the running field.
- R9: The request stream starts in the cycle after the start pulse, with busy_o 1 and req_valid_o 1 from then until the end of the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a field using the current parameters |
| base_odd_i | input | 32 | Odd-field base byte address |
| base_even_i | input | 32 | Even-field base byte address |
| pitch_i | input | 32 | Byte distance between consecutive line starts, must be a multiple of 4 |
| num_lines_i | input | 11 | Lines per field |
| num_bytes_i | input | 13 | Bytes fetched per line |
| req_valid_o | output | 1 | Read request present |
| req_ready_i | input | 1 | Bus master takes the request |
| req_addr_o | output | 32 | Dword read byte address |
| busy_o | output | 1 | A field is in progress |
| field_done_o | output | 1 | One-cycle pulse after the last request of a field |
| field_odd_o | output | 1 | 1 when the next or current field uses the odd base |
| cfg_err_o | output | 1 | Last start was refused for bad parameters |

## Verification
The bench targets the line-end turn. A design that added 4 there instead of the pitch, or that stepped from the last Dword address, would drift off the frame from the second line on. Byte counts that are not a multiple of 4 check the rounding: an off-by-one would drop or add a trailing Dword on every line. Random stalls on ready test request holding, where a leaking address would skip Dwords. Back-to-back fields, misaligned and empty configurations, and mid-field parameter changes or restarts test the parity toggle, the refusal path and the parameter capture. A design that got these wrong would fetch the same field twice, start with a bad pitch, or follow the new inputs partway through a field.

// File: rtl/field_addr_pkg.sv
package field_addr_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LINE_W = 11;
  localparam int unsigned BYTE_W = 13;
  localparam int unsigned DW_W   = BYTE_W - 1;
  localparam int unsigned STEP   = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [DW_W-1:0]   dw_t;

  typedef struct packed {
    addr_t base;
    addr_t pitch;
    line_t lines;
    dw_t   dwords;
  } cfg_t;
endpackage

// File: rtl/fag_cfg_reg.sv
module fag_cfg_reg
  import field_addr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  busy_i,
  input  addr_t base_i,
  input  addr_t pitch_i,
  input  line_t lines_i,
  input  byte_t bytes_i,
  output cfg_t  cfg_o,
  output logic  accept_o,
  output logic  cfg_err_o
);
  logic           bad;
  logic [BYTE_W:0] bytes_up;
  dw_t            dwords;

  assign bad      = (pitch_i[1:0] != 2'b00) || (lines_i == '0) || (bytes_i == '0);
  assign bytes_up = {1'b0, bytes_i} + (BYTE_W+1)'(STEP - 1);
  assign dwords   = dw_t'(bytes_up >> 2);
  assign accept_o = start_i && !busy_i && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      if (start_i && !busy_i) cfg_err_o <= bad;
      if (accept_o) begin
        cfg_o.base   <= base_i;
        cfg_o.pitch  <= pitch_i;
        cfg_o.lines  <= lines_i;
        cfg_o.dwords <= dwords;
      end
    end
  end

  // R7
  refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && bad |=> cfg_err_o && !busy_i);
endmodule

// File: rtl/fag_walk.sv
module fag_walk
  import field_addr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  logic  hs_i,
  input  line_t lines_i,
  input  dw_t   dwords_i,
  output logic  busy_o,
  output logic  line_last_o,
  output logic  field_last_o,
  output logic  done_o
);
  dw_t   dw_cnt;
  line_t line_cnt;

  assign line_last_o  = (dw_cnt == dwords_i - dw_t'(1));
  assign field_last_o = line_last_o && (line_cnt == lines_i - line_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      dw_cnt   <= '0;
      line_cnt <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_i) begin
        busy_o   <= 1'b1;
        dw_cnt   <= '0;
        line_cnt <= '0;
      end else if (hs_i) begin
        if (line_last_o) begin
          dw_cnt <= '0;
          if (field_last_o) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            line_cnt <= line_cnt + line_t'(1);
          end
        end else begin
          dw_cnt <= dw_cnt + dw_t'(1);
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/fag_addr.sv
module fag_addr
  import field_addr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  addr_t base_i,
  input  addr_t pitch_i,
  input  logic  hs_i,
  input  logic  line_last_i,
  input  logic  field_last_i,
  output addr_t addr_o
);
  addr_t line_start;
  addr_t next_line;

  assign next_line = line_start + pitch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_start <= '0;
      addr_o     <= '0;
    end else if (accept_i) begin
      line_start <= base_i;
      addr_o     <= base_i;
    end else if (hs_i) begin
      if (line_last_i) begin
        line_start <= next_line;
        addr_o     <= next_line;
      end else begin
        addr_o <= addr_o + addr_t'(STEP);
      end
    end
  end

  // R3
  dword_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_i && !line_last_i && !accept_i |=> addr_o == $past(addr_o) + addr_t'(STEP));
  // R4
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_i && line_last_i && !field_last_i && !accept_i
      |=> addr_o == $past(line_start) + $past(pitch_i));
endmodule

// File: rtl/field_addr_gen.sv
module field_addr_gen
  import field_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_odd_i,
  input  logic [ADDR_W-1:0] base_even_i,
  input  logic [ADDR_W-1:0] pitch_i,
  input  logic [LINE_W-1:0] num_lines_i,
  input  logic [BYTE_W-1:0] num_bytes_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              busy_o,
  output logic              field_done_o,
  output logic              field_odd_o,
  output logic              cfg_err_o
);
  cfg_t  cfg;
  logic  accept, hs, line_last, field_last;
  addr_t base_sel;

  assign base_sel    = field_odd_o ? base_odd_i : base_even_i;
  assign req_valid_o = busy_o;
  assign hs          = req_valid_o && req_ready_i;

  fag_cfg_reg u_cfg (
    .clk_i, .rst_ni, .start_i,
    .busy_i    (busy_o),
    .base_i    (base_sel),
    .pitch_i   (pitch_i),
    .lines_i   (num_lines_i),
    .bytes_i   (num_bytes_i),
    .cfg_o     (cfg),
    .accept_o  (accept),
    .cfg_err_o (cfg_err_o)
  );

  fag_walk u_walk (
    .clk_i, .rst_ni,
    .accept_i     (accept),
    .hs_i         (hs),
    .lines_i      (cfg.lines),
    .dwords_i     (cfg.dwords),
    .busy_o       (busy_o),
    .line_last_o  (line_last),
    .field_last_o (field_last),
    .done_o       (field_done_o)
  );

  fag_addr u_addr (
    .clk_i, .rst_ni,
    .accept_i     (accept),
    .base_i       (base_sel),
    .pitch_i      (cfg.pitch),
    .hs_i         (hs),
    .line_last_i  (line_last),
    .field_last_i (field_last),
    .addr_o       (req_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 field_odd_o <= 1'b1;
    else if (hs && field_last)   field_odd_o <= ~field_odd_o;
  end

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));
  // R5
  parity_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_done_o |-> field_odd_o != $past(field_odd_o));
  // R9
  start_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> req_valid_o);
endmodule

// File: tb/field_addr_gen_test.sv
`timescale 1ns/1ps
module field_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_odd = '0, base_even = '0, pitch = '0;
  logic [10:0] lines = '0;
  logic [12:0] nbytes = '0;
  logic        ready = 1'b0;
  int          rdy_mode = 0;
  logic        valid, busy, done, odd, err;
  logic [31:0] addr;

  int tests = 0, fails = 0;
  string tag = "R2";

  // reference state
  bit          m_busy = 0, m_done = 0, m_err = 0, m_odd = 1, m_stall = 0;
  int          m_line = 0, m_dw = 0, m_lines = 0, m_dws = 0;
  logic [31:0] m_base = '0, m_pitch = '0;

  always #10 clk = ~clk;

  field_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .base_odd_i(base_odd), .base_even_i(base_even), .pitch_i(pitch),
    .num_lines_i(lines), .num_bytes_i(nbytes),
    .req_valid_o(valid), .req_ready_i(ready), .req_addr_o(addr),
    .busy_o(busy), .field_done_o(done), .field_odd_o(odd), .cfg_err_o(err)
  );

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rdy_mode == 0) ready <= 1'b1;
    else               ready <= ($urandom % 3) != 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      m_done  = 0;
      m_stall = m_busy && !ready;
      if (!m_busy && start) begin
        if (pitch[1:0] != 0 || lines == 0 || nbytes == 0) m_err = 1;
        else begin
          m_err = 0; m_busy = 1; m_line = 0; m_dw = 0;
          m_base = m_odd ? base_odd : base_even;
          m_pitch = pitch; m_lines = int'(lines); m_dws = (int'(nbytes) + 3) / 4;
        end
      end else if (m_busy && ready) begin
        m_dw++;
        if (m_dw == m_dws) begin
          m_dw = 0; m_line++;
          if (m_line == m_lines) begin m_busy = 0; m_done = 1; m_odd = !m_odd; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string at;
      chk(tag,  "valid",  32'(valid), 32'(m_busy));
      chk(tag,  "busy",   32'(busy),  32'(m_busy));
      chk("R5", "done",   32'(done),  32'(m_done));
      chk("R5", "parity", 32'(odd),   32'(m_odd));
      chk("R7", "err",    32'(err),   32'(m_err));
      if (m_busy) begin
        at = m_stall ? "R6" : (m_dw != 0 ? "R3" : (m_line != 0 ? "R4" : "R2"));
        chk(at, "addr", addr, m_base + 32'(m_line) * m_pitch + 32'(m_dw * 4));
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && m_busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] p, input int l, input int b, input int mode, input string t);
    pitch = p; lines = 11'(l); nbytes = 13'(b); rdy_mode = mode; tag = t;
    pulse_start();
    wait_idle();
  endtask

  initial begin
    #3_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    base_odd = 32'h0000_1000; base_even = 32'h0000_8000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset valid", 32'(valid), 0);
    chk("R1", "reset err",   32'(err),   0);
    chk("R1", "reset odd",   32'(odd),   1);
    chk("R1", "reset done",  32'(done),  0);

    run(32'd64, 3, 16, 0, "R9");       // odd field, no stalls
    run(32'd32, 4, 10, 1, "R9");       // even field, stalls, rounded bytes (R3)
    run(32'd128, 1, 1, 1, "R5");       // single Dword field
    run(32'd256, 2, 4096, 1, "R5");    // long line
    run(32'd66, 2, 8, 0, "R7");        // misaligned pitch refused
    repeat (4) @(negedge clk);
    run(32'd64, 0, 8, 0, "R7");        // empty field refused
    run(32'd64, 2, 0, 0, "R7");
    // R8: parameter changes and restart mid-field are ignored
    pitch = 32'd48; lines = 11'd5; nbytes = 13'd20; rdy_mode = 1; tag = "R8";
    pulse_start();
    repeat (5) @(negedge clk);
    base_odd = 32'h00AB_0000; base_even = 32'h00CD_0000;
    pitch = 32'd1024; lines = 11'd1; nbytes = 13'd4;
    pulse_start();
    pitch = 32'd6;
    pulse_start();
    wait_idle();
    run(32'hFFFF_FF00, 3, 12, 1, "R4"); // wrap-around pitch
    run(32'd16, 2, 16, 0, "R4");        // pitch equals line length

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule